// File: doc/BRIEF.md
# SPI Master with Separately Selectable Clock Edges

This block is a single-target SPI master. Software-side logic hands it a start strobe, a transmit word and three configuration bits. It then runs one frame on SCLK, an active-low chip select, MOSI and MISO, and returns the received word with a one-cycle completion pulse. The three configuration bits are the SCLK idle level, the SCLK edge on which MOSI changes, and the SCLK edge on which MISO is captured.

The launch edge and the capture edge are chosen independently, so the block is not limited to the four classic phase/polarity pairings. One example is a converter that wants MOSI updated on the rising edge and MISO read on the same rising edge. The block handles this by capturing MISO first and only then moving MOSI to the next bit, both on that one edge.

SCLK comes from a programmable divider of the system clock. Each SCLK half period lasts a chosen number of system clocks, and one system clock per half period is the minimum.

Top module: `spi_edge_master`

## Requirements
- R1: While reset is asserted, and after it is released, cs_n is 1, sclk is 0, mosi is 0, done is 0 and busy is 0. Asserting reset in the middle of a frame raises cs_n at once.
- R2: Each frame gives exactly 32 SCLK transitions (2 × 16). SCLK moves to the latched `cfg_cpol` level when cs_n falls, rests at that level between frames, and is back at that level when the frame ends.
- R3: MOSI sends `tx_word` MSB first. Bit 15 is on MOSI before the first SCLK edge. MOSI changes only on the selected launch edge (`cfg_mosi_rise` = 1 selects rising, 0 selects falling). A launch edge moves to the next bit only if an edge of the other direction has occurred since the current bit appeared.
- R4: MISO is captured on every edge of the selected direction (`cfg_miso_rise` = 1 selects rising, 0 selects falling). The 16 captures fill `rx_word` MSB first.
- R5: When the launch edge and the capture edge are the same, MISO is captured from the value held before that edge, and MOSI changes afterwards. With idle-low SCLK and both edges rising, the first rising edge after cs_n falls captures bit 15.
- R6: The four classic modes are available as settings of {cpol, mosi_rise, miso_rise}: mode 0 = {0,0,1}, mode 1 = {0,1,0}, mode 2 = {1,1,0}, mode 3 = {1,0,1}.
- R7: One SCLK half period lasts `div_half` system clocks. A value of 0 is treated as 1, which gives a minimum division of 2.
- R8: Exactly one half period passes between cs_n falling and the first SCLK edge. Exactly one half period passes between the last SCLK edge and cs_n rising.
- R9: `done` is high for one system clock, in the cycle where cs_n rises. `rx_word` holds the new word from that cycle until the next frame completes.
- R10: The configuration bits, `div_half` and `tx_word` are latched on `start`. While `busy` is high, changes to these inputs and further `start` pulses have no effect, and a start pulse is not queued for later.
- R11: A peripheral that changes MISO on the master's own capture edge is read one bit late: a word w returns as {w[15], w[15:1]}. For example, 0x7FFF returns as 0x3FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| tx_word | input | 16 | Word to transmit |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_mosi_rise | input | 1 | 1 = MOSI changes on rising edge, 0 = on falling edge |
| cfg_miso_rise | input | 1 | 1 = MISO captured on rising edge, 0 = on falling edge |
| div_half | input | 8 | System clocks per SCLK half period (0 acts as 1) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rx_word | output | 16 | Last received word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions take for granted that `div_half` and the configuration inputs are meaningful only in the cycle of `start`. They also assume that MISO is settled in each system clock where SCLK toggles. The bench meets the second assumption with a peripheral model that reacts on the falling system-clock edge after each SCLK transition, so MISO never changes in the same cycle it is captured. The model reads MOSI as it was before each transition. It is set either to match the master's edges or to launch on the master's capture edge, and it changes configuration and pulses start during a frame only in the test that checks those inputs are ignored.

// File: rtl/spi_em_pkg.sv
package spi_em_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TRAIL
  } st_e;

  typedef struct packed {
    logic cpol;
    logic mosi_rise;
    logic miso_rise;
  } edge_cfg_t;
endpackage

// File: rtl/spi_em_tick.sv
module spi_em_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_n;
  logic             at_end;

  assign at_end = (cnt_q == half - DIV_W'(1));
  assign tick   = run && at_end;

  always_comb begin
    cnt_n = cnt_q;
    if (!run || at_end) cnt_n = '0;
    else                cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R7: the half-period counter never passes the programmed length
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));
endmodule

// File: rtl/spi_em_shift.sv
module spi_em_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] tx_word,
  input  logic          edge_en,
  input  logic          edge_rise,
  input  logic          mosi_rise,
  input  logic          miso_rise,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx_data
);
  logic [DW-1:0] tx_q, tx_n;
  logic [DW-1:0] rx_q, rx_n;
  logic          seen_q, seen_n;
  logic          mosi_q, mosi_n;
  logic          is_cap, is_launch;

  assign is_cap    = edge_en && (edge_rise == miso_rise);
  assign is_launch = edge_en && (edge_rise == mosi_rise);

  always_comb begin
    tx_n   = tx_q;
    rx_n   = rx_q;
    seen_n = seen_q;
    mosi_n = mosi_q;
    if (load) begin
      mosi_n = tx_word[DW-1];
      tx_n   = {tx_word[DW-2:0], 1'b0};
      seen_n = 1'b0;
    end else if (edge_en) begin
      // capture uses the pre-edge MISO; MOSI moves in the same step
      if (is_cap) rx_n = {rx_q[DW-2:0], miso};
      if (is_launch) begin
        if (seen_q) begin
          mosi_n = tx_q[DW-1];
          tx_n   = {tx_q[DW-2:0], 1'b0};
          seen_n = 1'b0;
        end
      end else begin
        seen_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      seen_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      seen_q <= seen_n;
      mosi_q <= mosi_n;
    end
  end

  assign mosi    = mosi_q;
  assign rx_data = rx_q;

  // R3: MOSI holds across an edge that is not the launch edge
  a_r3_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en && !load && (edge_rise != mosi_rise)) |=> $stable(mosi_q));
  // R5: a capture edge stores the MISO level seen at that edge
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cap && !load) |=> (rx_q[0] == $past(miso)));
endmodule

// File: rtl/spi_edge_master.sv
module spi_edge_master #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              cfg_cpol,
  input  logic              cfg_mosi_rise,
  input  logic              cfg_miso_rise,
  input  logic [DIV_W-1:0]  div_half,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  import spi_em_pkg::*;

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic rs1_q, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_q <= rs1_q;
    end
  end

  st_e               st_q, st_n;
  edge_cfg_t         cfg_q, cfg_n;
  logic [DIV_W-1:0]  half_q, half_n;
  logic              sclk_q, sclk_n;
  logic              cs_q, cs_n_nx;
  logic              done_q, done_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [EDGE_W-1:0] ecnt_q, ecnt_n;
  logic              load, edge_en, tick;
  logic [DATA_W-1:0] rx_data;

  spi_em_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_q),
    .run   (st_q != ST_IDLE),
    .half  (half_q),
    .tick  (tick)
  );

  spi_em_shift #(.DW(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_q),
    .load      (load),
    .tx_word   (tx_word),
    .edge_en   (edge_en),
    .edge_rise (~sclk_q),
    .mosi_rise (cfg_q.mosi_rise),
    .miso_rise (cfg_q.miso_rise),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_data)
  );

  always_comb begin
    st_n    = st_q;
    cfg_n   = cfg_q;
    half_n  = half_q;
    sclk_n  = sclk_q;
    cs_n_nx = cs_q;
    done_n  = 1'b0;
    rx_n    = rx_q;
    ecnt_n  = ecnt_q;
    load    = 1'b0;
    edge_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_n    = ST_LEAD;
        cfg_n   = '{cpol: cfg_cpol, mosi_rise: cfg_mosi_rise, miso_rise: cfg_miso_rise};
        half_n  = (div_half == '0) ? DIV_W'(1) : div_half;
        sclk_n  = cfg_cpol;
        cs_n_nx = 1'b0;
        ecnt_n  = '0;
        load    = 1'b1;
      end
      ST_LEAD: if (tick) begin
        st_n    = ST_RUN;
        sclk_n  = ~sclk_q;
        edge_en = 1'b1;
        ecnt_n  = ecnt_q + EDGE_W'(1);
      end
      ST_RUN: if (tick) begin
        sclk_n  = ~sclk_q;
        edge_en = 1'b1;
        ecnt_n  = ecnt_q + EDGE_W'(1);
        if (ecnt_q == LAST_EDGE) st_n = ST_TRAIL;
      end
      ST_TRAIL: if (tick) begin
        st_n    = ST_IDLE;
        cs_n_nx = 1'b1;
        done_n  = 1'b1;
        rx_n    = rx_data;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      half_q <= DIV_W'(1);
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      rx_q   <= '0;
      ecnt_q <= '0;
    end else begin
      st_q   <= st_n;
      cfg_q  <= cfg_n;
      half_q <= half_n;
      sclk_q <= sclk_n;
      cs_q   <= cs_n_nx;
      done_q <= done_n;
      rx_q   <= rx_n;
      ecnt_q <= ecnt_n;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sclk    = sclk_q;
  assign cs_n    = cs_q;

  // R9: completion pulse lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);
  // R9: completion coincides with chip select release
  a_r9_done_cs: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> $rose(cs_n));
  // R2: no SCLK movement between frames
  a_r2_idle_sclk: assert property (@(posedge clk) disable iff (!rst_q)
    (cs_n && $past(cs_n)) |-> $stable(sclk));
  // R2: SCLK is back at the idle level when the frame closes
  a_r2_end_level: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> (sclk == cfg_q.cpol));
  // R10: latched settings hold for the whole frame
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && $past(busy)) |-> ($stable(cfg_q) && $stable(half_q)));
  // R8: SCLK transitions only inside an asserted chip select
  a_r8_edges_inside: assert property (@(posedge clk) disable iff (!rst_q)
    (!$stable(sclk) && !$fell(cs_n)) |-> (!cs_n && $past(!cs_n)));
endmodule

// File: tb/sim_spi_edge_master.sv
module sim_spi_edge_master;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] tx_word;
  logic        cfg_cpol, cfg_mosi_rise, cfg_miso_rise;
  logic [7:0]  div_half;
  logic        busy, done, sclk, cs_n, mosi, miso;
  logic [15:0] rx_word;

  spi_edge_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .cfg_cpol(cfg_cpol), .cfg_mosi_rise(cfg_mosi_rise), .cfg_miso_rise(cfg_miso_rise),
    .div_half(div_half), .busy(busy), .done(done), .rx_word(rx_word),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural peripheral, acts on the falling system-clock edge
  logic [15:0] s_word, s_tx, s_rx;
  logic        s_samp_rise, s_launch_rise, s_seen;
  logic        p_sclk, p_cs, p_mosi;
  int          cyc = 0, s_edges = 0, t_fall = 0, t_first = 0, t_last = 0, t_rise = 0, n_done = 0;

  initial begin
    miso = 1'b0; s_tx = '0; s_rx = '0; s_seen = 1'b0;
    p_sclk = 1'b0; p_cs = 1'b1; p_mosi = 1'b0;
    s_word = '0; s_samp_rise = 1'b1; s_launch_rise = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (done) n_done++;
    if (p_cs && !cs_n) begin
      miso = s_word[15]; s_tx = {s_word[14:0], 1'b0}; s_seen = 1'b0;
      s_edges = 0; t_fall = cyc;
    end else if (!cs_n && (sclk != p_sclk)) begin
      s_edges++;
      if (s_edges == 1) t_first = cyc;
      t_last = cyc;
      if (sclk == s_samp_rise) s_rx = {s_rx[14:0], p_mosi};
      if (sclk == s_launch_rise) begin
        if (s_seen) begin miso = s_tx[15]; s_tx = {s_tx[14:0], 1'b0}; s_seen = 1'b0; end
      end else s_seen = 1'b1;
    end
    if (!p_cs && cs_n) t_rise = cyc;
    p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
  end

  typedef struct packed {
    logic        cp, mo, mi, mis;
    logic [7:0]  dv;
    logic [15:0] tw, sw, ex;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'd2, 16'hA5C3, 16'h7FFF, 16'h7FFF}, // R6 mode 0
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 16'h1234, 16'h8001, 16'h8001}, // R6 mode 1
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 16'hFFFF, 16'h0000, 16'h0000}, // R6 mode 2
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd4, 16'h0001, 16'hC0DE, 16'hC0DE}, // R6 mode 3
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd2, 16'h8000, 16'h7FFF, 16'h7FFF}, // R5 same rising edge
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 16'h5A5A, 16'h1357, 16'h1357}, // R7 zero divider
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd2, 16'h3C3C, 16'h7FFF, 16'h3FFF}, // R11 mismatched peripheral
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'd2, 16'h0F0F, 16'hABCD, 16'hABCD}, // R5 idle-high same edge
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 16'hF00F, 16'h2468, 16'h2468}  // R4 both falling
  };

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b1;
    while (!done) begin
      @(negedge clk); #1;
      n++;
      if (n > 5000) begin ok = 1'b0; break; end
    end
  endtask

  task automatic run_vec(input vec_t v, input bit disturb);
    bit ok;
    int eff;
    eff = (v.dv == 0) ? 1 : int'(v.dv);
    s_word = v.sw; s_samp_rise = ~v.mo; s_launch_rise = v.mis ? v.mi : ~v.mi;
    @(negedge clk);
    cfg_cpol = v.cp; cfg_mosi_rise = v.mo; cfg_miso_rise = v.mi;
    div_half = v.dv; tx_word = v.tw; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    n_done = 0;
    if (disturb) begin
      repeat (20) @(negedge clk);
      cfg_cpol = ~v.cp; cfg_mosi_rise = ~v.mo; cfg_miso_rise = ~v.mi;
      div_half = 8'd1; tx_word = ~v.tw; start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R9 done within watchdog", 32'(ok), 32'd1);
    chk(rx_word == v.ex, "R4/R5/R6/R11 rx_word", 32'(rx_word), 32'(v.ex));
    chk(s_rx == v.tw, "R3 peripheral got tx_word", 32'(s_rx), 32'(v.tw));
    chk(s_edges == 32, "R2 edge count", 32'(s_edges), 32'd32);
    chk((t_first - t_fall) == eff, "R7 R8 lead half period", 32'(t_first - t_fall), 32'(eff));
    chk((t_rise - t_last) == eff, "R8 trail half period", 32'(t_rise - t_last), 32'(eff));
    chk(sclk == v.cp, "R2 idle level after frame", 32'(sclk), 32'(v.cp));
    @(negedge clk); #1;
    chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'd0);
    if (disturb) begin
      repeat (6) @(negedge clk);
      #1;
      chk(busy == 1'b0 && cs_n == 1'b1, "R10 start during busy not queued", 32'(busy), 32'd0);
      chk(n_done == 1, "R10 single completion", 32'(n_done), 32'd1);
      chk(rx_word == v.ex, "R9 rx_word held", 32'(rx_word), 32'(v.ex));
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; tx_word = '0; div_half = 8'd2;
    cfg_cpol = 1'b0; cfg_mosi_rise = 1'b0; cfg_miso_rise = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 reset pins", {29'd0, cs_n, sclk, mosi}, 32'h4);
    chk(done == 1'b0 && busy == 1'b0, "R1 reset status", {30'd0, done, busy}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after release", {30'd0, cs_n, busy}, 32'h2);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R10: inputs changed and start pulsed mid-frame
    run_vec(VECS[4], 1'b1);

    // R1: reset in the middle of a frame
    @(negedge clk);
    cfg_cpol = 1'b1; cfg_mosi_rise = 1'b0; cfg_miso_rise = 1'b1; div_half = 8'd3;
    tx_word = 16'h1111; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cs_n == 1'b1, "R1 mid-frame reset cs_n", 32'(cs_n), 32'd1);
    chk(sclk == 1'b0 && busy == 1'b0, "R1 mid-frame reset sclk/busy", {30'd0, sclk, busy}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_vec(VECS[0], 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule